// File: doc/BRIEF.md
# Adaptive slope delta decoder

This block turns a serial delta-modulated bit stream back into signed PCM samples. Each accepted bit passes through a fixed loop: a three-bit history register, a run detector, a syllabic envelope filter, a signed step, and a leaky integrator. The loop matches the feedback path of the transmitting encoder bit for bit. The integrator value, clamped to the output width, is the reconstructed sample. One sample leaves the block for every accepted bit. The stream must already be baseband. The final analog smoothing filter sits outside the block.

A four-state sequencer spreads the work for one bit over four clock cycles:
- IDLE waits for `bit_valid` and shifts the bit into the history (IDLE→ADAPT).
- ADAPT evaluates the run flag and updates the syllabic envelope (ADAPT→INTEG).
- INTEG applies the leak and the signed step to the integrator (INTEG→EMIT).
- EMIT registers the clamped sample and strobes `sample_valid` (EMIT→IDLE).

Bits offered while the sequencer is outside IDLE are dropped, so the bit rate must stay at or below one quarter of the clock rate. The input `rate_32k` picks the leak shift amounts. With it low the stream is taken as 16 kbit/s, with it high as 32 kbit/s. The two settings give the same time constants in milliseconds.

Top module: `cvsd_decoder`

## Requirements
- R1: After reset, `sample_out` is 0, `sample_valid` is 0 and `run_hit` is 0. The history holds 3'b010, and the envelope and the integrator are 0.
- R2: Each accepted bit shifts into history bit 0, and the older bits move up one place. The run flag is 1 exactly when all three history bits are equal. `run_hit` reports the flag for the bit whose sample it accompanies.
- R3: The envelope E changes once per bit, with k = 6 when `rate_32k`=0 and k = 7 when `rate_32k`=1. When the flag is 1, E becomes E + ((SYL_TARGET − E) >> k). When the flag is 0, E becomes E − (E >> k).
- R4: The step is STEP_MIN + E, using the updated E. A received 1 adds the step to the integrator and a received 0 subtracts it.
- R5: The integrator A leaks before the step is applied, as A − (A >>> j), where >>> is an arithmetic shift. j = 4 when `rate_32k`=0 and j = 5 when `rate_32k`=1.
- R6: `sample_out` equals A clamped to the signed OUT_W range, [−32768, 32767] at the default width.
- R7: `sample_valid` is a single-cycle pulse. It goes high after the fourth rising edge, counting the edge that accepted the bit, and there is exactly one pulse per accepted bit.
- R8: A `bit_valid` that arrives while the sequencer is outside IDLE is ignored. It changes no history, envelope, integrator or output.
- R9: `rate_32k` is sampled during each bit's ADAPT and INTEG cycles, so a change of rate takes effect from the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Received delta bit |
| rate_32k | input | 1 | 0: 16 kbit/s leak shifts, 1: 32 kbit/s leak shifts |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_out | output | OUT_W | Signed reconstructed sample |
| run_hit | output | 1 | Run flag for the bit of this sample |

## Verification
The bench plays the repeating zero-run and thirty-percent-run reference streams at both rates, then a switch between them, so the envelope both charges and decays. A wrong shift amount or a charge/discharge swap makes the predicted samples drift apart within a few bits. Long runs of ones and then zeros at the 32 kbit/s setting drive the integrator past the output range. A missing or sign-wrong clamp shows up as wrapped samples. Pulses of `bit_valid` injected during the busy cycles check R8: a design that accepted them would emit extra samples and shift its history, and every later sample would then disagree.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
    localparam int HIST_LEN = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADAPT = 2'd1,
        ST_INTEG = 2'd2,
        ST_EMIT  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cvsd_run_detect.sv
module cvsd_run_detect
    import cvsd_pkg::*;
#(
    parameter logic [HIST_LEN-1:0] RESET_HIST = 3'b010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                bit_in,
    output logic [HIST_LEN-1:0] hist,
    output logic                run_flag
);
    logic [HIST_LEN-1:0] hist_q;
    logic [HIST_LEN-1:0] same;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist_q <= RESET_HIST;
        else if (shift_en)
            hist_q <= {hist_q[HIST_LEN-2:0], bit_in};
    end

    assign same[0] = 1'b1;
    for (genvar g = 1; g < HIST_LEN; g++) begin : g_cmp
        assign same[g] = (hist_q[g] == hist_q[0]);
    end

    assign run_flag = &same;
    assign hist     = hist_q;

    // R2
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[HIST_LEN-1:1] == $past(hist_q[HIST_LEN-2:0])));
endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic #(
    parameter int SYL_W      = 16,
    parameter int SYL_TARGET = 1536,
    parameter int STEP_MIN   = 96,
    parameter int SH_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adapt_en,
    input  logic             run_flag,
    input  logic [SH_W-1:0]  shift_k,
    output logic [SYL_W:0]   step
);
    localparam logic [SYL_W-1:0] TARGET_V = SYL_W'(SYL_TARGET);
    localparam logic [SYL_W:0]   MIN_V    = (SYL_W+1)'(STEP_MIN);

    logic [SYL_W-1:0] env_q;
    logic [SYL_W-1:0] env_d;
    logic [SYL_W-1:0] gap;
    logic [SYL_W-1:0] rise;
    logic [SYL_W-1:0] fall;

    always_comb begin
        gap   = TARGET_V - env_q;
        rise  = gap >> shift_k;
        fall  = env_q >> shift_k;
        env_d = run_flag ? (env_q + rise) : (env_q - fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            env_q <= '0;
        else if (adapt_en)
            env_q <= env_d;
    end

    assign step = {1'b0, env_q} + MIN_V;

    // R3
    env_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adapt_en && !run_flag) |=> (env_q <= $past(env_q)));
    // R3
    env_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adapt_en && run_flag) |=> (env_q >= $past(env_q)));
    // R3
    env_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        env_q <= TARGET_V);
endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator #(
    parameter int ACC_W = 20,
    parameter int SYL_W = 16,
    parameter int SH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    integ_en,
    input  logic                    polarity,
    input  logic [SYL_W:0]          step,
    input  logic [SH_W-1:0]         shift_j,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] step_s;
    logic signed [ACC_W-1:0] leak;
    logic signed [ACC_W-1:0] acc_d;

    always_comb begin
        step_s = $signed({{(ACC_W-SYL_W-1){1'b0}}, step});
        leak   = acc_q >>> shift_j;
        acc_d  = polarity ? (acc_q - leak + step_s) : (acc_q - leak - step_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (integ_en)
            acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R4
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_en && polarity && acc_q[ACC_W-1]) |=> (acc_q > $past(acc_q)));
    // R4
    neg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_en && !polarity && !acc_q[ACC_W-1]) |=> (acc_q < $past(acc_q)));
endmodule

// File: rtl/cvsd_decoder.sv
module cvsd_decoder
    import cvsd_pkg::*;
#(
    parameter int OUT_W      = 16,
    parameter int ACC_W      = 20,
    parameter int SYL_W      = 16,
    parameter int SYL_TARGET = 1536,
    parameter int STEP_MIN   = 96,
    parameter int SYL_SH_LO  = 6,
    parameter int INT_SH_LO  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_valid,
    input  logic                    bit_in,
    input  logic                    rate_32k,
    output logic                    sample_valid,
    output logic signed [OUT_W-1:0] sample_out,
    output logic                    run_hit
);
    localparam int SH_W = 4;
    localparam logic signed [ACC_W-1:0] HI_A = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO_A = -ACC_W'(2 ** (OUT_W - 1));

    seq_state_t state_q, state_d;

    logic                    shift_en, adapt_en, integ_en;
    logic [HIST_LEN-1:0]     hist;
    logic                    run_flag;
    logic [SYL_W:0]          step;
    logic signed [ACC_W-1:0] acc;
    logic [SH_W-1:0]         shift_k, shift_j;
    logic signed [OUT_W-1:0] clamped;

    assign shift_en = (state_q == ST_IDLE) && bit_valid;
    assign adapt_en = (state_q == ST_ADAPT);
    assign integ_en = (state_q == ST_INTEG);
    assign shift_k  = SH_W'(SYL_SH_LO) + SH_W'(rate_32k);
    assign shift_j  = SH_W'(INT_SH_LO) + SH_W'(rate_32k);

    cvsd_run_detect u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (bit_in),
        .hist     (hist),
        .run_flag (run_flag)
    );

    cvsd_syllabic #(
        .SYL_W      (SYL_W),
        .SYL_TARGET (SYL_TARGET),
        .STEP_MIN   (STEP_MIN),
        .SH_W       (SH_W)
    ) u_syl (
        .clk      (clk),
        .rst_n    (rst_n),
        .adapt_en (adapt_en),
        .run_flag (run_flag),
        .shift_k  (shift_k),
        .step     (step)
    );

    cvsd_integrator #(
        .ACC_W (ACC_W),
        .SYL_W (SYL_W),
        .SH_W  (SH_W)
    ) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .integ_en (integ_en),
        .polarity (hist[0]),
        .step     (step),
        .shift_j  (shift_j),
        .acc      (acc)
    );

    always_comb begin
        if (acc > HI_A)
            clamped = HI_A[OUT_W-1:0];
        else if (acc < LO_A)
            clamped = LO_A[OUT_W-1:0];
        else
            clamped = acc[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (bit_valid) state_d = ST_ADAPT;
            ST_ADAPT: state_d = ST_INTEG;
            ST_INTEG: state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_valid <= 1'b0;
            sample_out   <= '0;
            run_hit      <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            unique case (state_q)
                ST_EMIT: begin
                    sample_valid <= 1'b1;
                    sample_out   <= clamped;
                    run_hit      <= run_flag;
                end
                ST_IDLE, ST_ADAPT, ST_INTEG: ;
            endcase
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);
    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && bit_valid) |=> $stable(hist));
    // R6
    clamp_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && acc > HI_A) |-> (sample_out == HI_A[OUT_W-1:0]));
    // R6
    clamp_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && acc < LO_A) |-> (sample_out == LO_A[OUT_W-1:0]));
    // R2
    run_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && run_hit) |-> (hist == '0 || hist == '1));
endmodule

// File: tb/cvsd_decoder_test.sv
module cvsd_decoder_test;
    localparam int OUT_W      = 16;
    localparam int SYL_TARGET = 1536;
    localparam int STEP_MIN   = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic rate_32k = 1'b0;
    logic sample_valid;
    logic signed [OUT_W-1:0] sample_out;
    logic run_hit;

    int compared = 0;
    int mismatched = 0;

    int    exp_s[$];
    int    exp_f[$];
    string exp_t[$];

    logic [2:0] m_hist = 3'b010;
    int m_env = 0;
    int m_acc = 0;

    always #4 clk = ~clk;

    cvsd_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_valid    (bit_valid),
        .bit_in       (bit_in),
        .rate_32k     (rate_32k),
        .sample_valid (sample_valid),
        .sample_out   (sample_out),
        .run_hit      (run_hit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_bit(input logic b, input string tag);
        int flag, k, j, step, outv;
        m_hist = {m_hist[1:0], b};
        flag = (m_hist == 3'b000 || m_hist == 3'b111) ? 1 : 0;
        k = rate_32k ? 7 : 6;
        j = rate_32k ? 5 : 4;
        if (flag == 1) m_env = m_env + ((SYL_TARGET - m_env) >>> k);
        else           m_env = m_env - (m_env >>> k);
        step  = STEP_MIN + m_env;
        m_acc = m_acc - (m_acc >>> j) + (b ? step : -step);
        outv  = (m_acc > 32767) ? 32767 : ((m_acc < -32768) ? -32768 : m_acc);
        exp_s.push_back(outv);
        exp_f.push_back(flag);
        exp_t.push_back(tag);
    endtask

    task automatic send_bit(input logic b, input string tag);
        model_bit(b, tag);
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
        @(negedge clk); bit_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // R8: second pulse lands while the sequencer is in INTEG
    task automatic send_with_glitch(input logic b);
        model_bit(b, "R8");
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
        @(negedge clk); bit_valid = 1'b0;
        @(negedge clk); bit_valid = 1'b1; bit_in = ~b;
        @(negedge clk); bit_valid = 1'b0;
    endtask

    task automatic play(input logic [39:0] pat, input int len, input int reps, input string tag);
        for (int r = 0; r < reps; r++)
            for (int i = len - 1; i >= 0; i--)
                send_bit(pat[i], tag);
    endtask

    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            if (exp_s.size() == 0) begin
                check(1'b0, "R7", 1, 0);
            end else begin
                int es, ef;
                string et;
                es = exp_s.pop_front();
                ef = exp_f.pop_front();
                et = exp_t.pop_front();
                check(int'(sample_out) == es, et, int'(sample_out), es);
                check(int'(run_hit) == ef, "R2", int'(run_hit), ef);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during and right after reset
        check(sample_out == 0, "R1", int'(sample_out), 0);
        check(sample_valid == 0, "R1", int'(sample_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sample_valid == 0, "R1", int'(sample_valid), 0);
        check(run_hit == 0, "R1", int'(run_hit), 0);

        // R4 first bits after reset, then R7 latency probe
        send_bit(1'b1, "R4");
        send_bit(1'b0, "R4");
        model_bit(1'b1, "R7");
        @(negedge clk); bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk); bit_valid = 1'b0;
        check(sample_valid == 0, "R7", int'(sample_valid), 0);
        @(negedge clk);
        check(sample_valid == 0, "R7", int'(sample_valid), 0);
        @(negedge clk);
        check(sample_valid == 0, "R7", int'(sample_valid), 0);
        // the monitor sees the pulse on the following negedge

        // R3 R5: zero-run pattern, then 30% pattern, then back (16 kbit/s)
        play(40'h00000DB492, 20, 8, "R5");
        play(40'h00000FB412, 20, 25, "R3");
        play(40'h00000DB492, 20, 25, "R3");

        // R8: glitch pulses in the busy window
        for (int n = 0; n < 6; n++) send_with_glitch(n[0]);
        send_bit(1'b1, "R8");

        // R9: 32 kbit/s shifts
        rate_32k = 1'b1;
        play(40'hDB54924AB6, 40, 6, "R9");
        play(40'hFDAA10255E, 40, 12, "R9");

        // R6: long runs drive the integrator past both rails
        for (int n = 0; n < 300; n++) send_bit(1'b1, "R6");
        for (int n = 0; n < 300; n++) send_bit(1'b0, "R6");

        // R9: drop back to 16 kbit/s mid-stream
        rate_32k = 1'b0;
        play(40'h00000FB412, 20, 5, "R9");

        repeat (8) @(negedge clk);
        check(exp_s.size() == 0, "R7", exp_s.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule